// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block takes a set of level-sensitive hardware interrupt lines and one software interrupt request. The software request carries its own handler address. Every request is latched as pending. Each cycle the block picks the most urgent pending source and compares it against the interrupt that is running now. When it takes a request, it loads an interrupt register and pulses a take strobe for one cycle.

For a hardware source the interrupt register holds an offset into a contiguous handler table. The fetch address is then a fixed table base plus that offset. For a software source the register holds the absolute handler address, and the fetch address equals it.

A more urgent request may cut into a handler that is still running. The interrupted context then goes onto an internal last-in-first-out stack. A one-cycle completion pulse from the processor restores the most recently suspended context. When nothing is suspended, the completion pulse returns the block to idle, where the register reads zero.

Top module: `nested_irq_ctrl`

## Requirements
- R1: Out of reset, and whenever no interrupt is running, `irq_reg_o` and `irq_addr_o` read zero, `irq_active_o` is low and `irq_id_o` equals N_HW+1.
- R2: A request on hardware line i that is sampled at one clock edge is taken at the next edge, provided it out-ranks the running level. In the cycle after that edge, `irq_take_o` is high for exactly one cycle, `irq_id_o` equals i and `irq_reg_o` equals i*VEC_STRIDE.
- R3: While a hardware interrupt runs, `irq_addr_o` equals VEC_BASE plus `irq_reg_o`. While a software interrupt runs, `irq_addr_o` equals `irq_reg_o`.
- R4: A taken software request has `irq_id_o` equal to N_HW. Its `irq_reg_o` is the `sw_addr_i` value captured in the cycle the software request became pending. A later software request that arrives while one is already pending does not replace the captured address.
- R5: Rank is fixed: hardware line 0 is the most urgent, higher line numbers are less urgent, and the software source ranks below every hardware line. When several requests are pending, the most urgent one is taken first.
- R6: A pending request that out-ranks the running interrupt preempts it. The running context (source, identity, register) is pushed onto the stack.
- R7: A pending request of equal or lower rank than the running interrupt does not preempt. It is taken once completions unwind the running level to one it out-ranks.
- R8: When `irq_done_i` is high while an interrupt runs, the most recently suspended context is restored, or the block goes idle if the stack is empty. When `irq_done_i` is high while idle, it has no effect.
- R9: The stack holds STACK_DEPTH suspended contexts. If a preempting request arrives while the stack is full, the request stays pending, the running interrupt is unchanged, and `irq_overflow_o` is high in each cycle the request is held back.
- R10: A pending bit clears when its interrupt is taken. A single-cycle request is therefore taken exactly once.
- R11: If a completion and a preempting request fall on the same edge, the completion is processed first. The request is considered at the following edge, so `irq_take_o` stays low in the cycle after a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_req_i | input | N_HW | Hardware request lines, level-sensitive, line 0 most urgent |
| sw_req_i | input | 1 | Software interrupt request |
| sw_addr_i | input | ADDR_W | Absolute handler address for the software request |
| irq_done_i | input | 1 | One-cycle completion pulse for the running handler |
| irq_take_o | output | 1 | One-cycle strobe: a new interrupt was taken |
| irq_active_o | output | 1 | An interrupt is running |
| irq_id_o | output | $clog2(N_HW+2) | Running source: line index, N_HW for software, N_HW+1 when idle |
| irq_reg_o | output | ADDR_W | Interrupt register: offset for hardware, address for software, zero when idle |
| irq_addr_o | output | ADDR_W | Handler fetch address |
| irq_overflow_o | output | 1 | A preempting request is held back because the stack is full |

## Verification
The hardest state to reach from the ports is a full stack with an even more urgent request waiting. That needs a chain of strictly rising ranks with no completion in between. The bench builds it by overriding the stack depth to two. It then stacks a software request under lines 3 and 2 and fires line 1, which must be held back. From there it unwinds with completion pulses and checks each restored level. It also confirms that the waiting line enters on the edge after a completion and not on the same edge. A behavioural model with a queue for the stack then follows a long sparse random run and is compared on every cycle.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_HW   = 2'd1,
    SRC_SW   = 2'd2
  } src_e;
endpackage

// File: rtl/nirq_pending.sv
module nirq_pending #(
  parameter int N_HW   = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_HW-1:0]   hw_req_i,
  input  logic              sw_req_i,
  input  logic [ADDR_W-1:0] sw_addr_i,
  input  logic [N_HW-1:0]   hw_clr_i,
  input  logic              sw_clr_i,
  output logic [N_HW-1:0]   hw_pend_o,
  output logic              sw_pend_o,
  output logic [ADDR_W-1:0] sw_addr_o
);
  logic sw_keep;
  assign sw_keep = sw_pend_o & ~sw_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_pend_o <= '0;
      sw_pend_o <= 1'b0;
      sw_addr_o <= '0;
    end else begin
      hw_pend_o <= (hw_pend_o & ~hw_clr_i) | hw_req_i;
      sw_pend_o <= sw_keep | sw_req_i;
      // first request wins the address until it is taken
      if (sw_req_i && !sw_keep) sw_addr_o <= sw_addr_i;
    end
  end

  AST_CLR_ONLY_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_clr_i & ~hw_pend_o) == '0); // R10
  AST_SW_CLR_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr_i |-> sw_pend_o); // R10
  AST_SW_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_pend_o && !sw_clr_i) |=> $stable(sw_addr_o)); // R4
endmodule

// File: rtl/nirq_arbiter.sv
module nirq_arbiter #(
  parameter int N_HW = 4,
  parameter int ID_W = 3
) (
  input  logic [N_HW-1:0] hw_pend_i,
  input  logic            sw_pend_i,
  output logic            valid_o,
  output logic [ID_W-1:0] id_o
);
  // lowest index wins; software sits below every line
  always_comb begin
    valid_o = sw_pend_i;
    id_o    = ID_W'(N_HW);
    for (int i = N_HW - 1; i >= 0; i--) begin
      if (hw_pend_i[i]) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/nirq_stack.sv
module nirq_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     mem_q [DEPTH];

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_o   = empty_o ? '0 : mem_q[PTR_W'(cnt_q - 1'b1)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (push_i && !full_o)  cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o)  cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[PTR_W'(cnt_q)] <= din_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R8
  AST_NO_PUSH_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)); // R11
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nirq_pkg::*;
#(
  parameter int N_HW        = 4,
  parameter int ADDR_W      = 16,
  parameter int VEC_BASE    = 'h0100,
  parameter int VEC_STRIDE  = 8,
  parameter int STACK_DEPTH = 4,
  localparam int ID_W       = $clog2(N_HW + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_HW-1:0]   hw_req_i,
  input  logic              sw_req_i,
  input  logic [ADDR_W-1:0] sw_addr_i,
  input  logic              irq_done_i,
  output logic              irq_take_o,
  output logic              irq_active_o,
  output logic [ID_W-1:0]   irq_id_o,
  output logic [ADDR_W-1:0] irq_reg_o,
  output logic [ADDR_W-1:0] irq_addr_o,
  output logic              irq_overflow_o
);
  localparam logic [ID_W-1:0] IDLE_ID = ID_W'(N_HW + 1);
  localparam logic [ID_W-1:0] SW_ID   = ID_W'(N_HW);
  localparam int              ENT_W   = 2 + ID_W + ADDR_W;

  src_e              cur_src_q;
  logic [ID_W-1:0]   cur_id_q;
  logic [ADDR_W-1:0] cur_reg_q;
  logic              take_q, ovf_q;

  logic [N_HW-1:0]   hw_pend, hw_clr;
  logic              sw_pend, sw_clr;
  logic [ADDR_W-1:0] sw_addr_q;
  logic              cand_valid;
  logic [ID_W-1:0]   cand_id;
  logic              cand_hw;
  logic [ID_W-1:0]   cur_lvl;
  logic              active, done_eff, preempt, blocked, take, push, pop;
  logic              stk_empty, stk_full;
  logic [ENT_W-1:0]  stk_top;
  logic [ADDR_W-1:0] new_reg;

  nirq_pending #(.N_HW(N_HW), .ADDR_W(ADDR_W)) u_pending (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_req_i (hw_req_i),
    .sw_req_i (sw_req_i),
    .sw_addr_i(sw_addr_i),
    .hw_clr_i (hw_clr),
    .sw_clr_i (sw_clr),
    .hw_pend_o(hw_pend),
    .sw_pend_o(sw_pend),
    .sw_addr_o(sw_addr_q)
  );

  nirq_arbiter #(.N_HW(N_HW), .ID_W(ID_W)) u_arbiter (
    .hw_pend_i(hw_pend),
    .sw_pend_i(sw_pend),
    .valid_o  (cand_valid),
    .id_o     (cand_id)
  );

  nirq_stack #(.DEPTH(STACK_DEPTH), .W(ENT_W)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .din_i  ({cur_src_q, cur_id_q, cur_reg_q}),
    .top_o  (stk_top),
    .empty_o(stk_empty),
    .full_o (stk_full)
  );

  assign active   = (cur_src_q != SRC_IDLE);
  assign cur_lvl  = active ? cur_id_q : IDLE_ID;
  assign cand_hw  = (cand_id < SW_ID);
  assign done_eff = irq_done_i && active;
  assign preempt  = cand_valid && (cand_id < cur_lvl);
  assign blocked  = preempt && active && stk_full;
  assign take     = preempt && !done_eff && !blocked;
  assign push     = take && active;
  assign pop      = done_eff && !stk_empty;
  assign sw_clr   = take && !cand_hw;
  assign new_reg  = cand_hw ? ADDR_W'(int'(cand_id) * VEC_STRIDE) : sw_addr_q;

  for (genvar g = 0; g < N_HW; g++) begin : g_clr
    assign hw_clr[g] = take && (cand_id == ID_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_src_q <= SRC_IDLE;
      cur_id_q  <= IDLE_ID;
      cur_reg_q <= '0;
      take_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      take_q <= take;
      ovf_q  <= blocked && !done_eff;
      if (done_eff) begin
        if (!stk_empty) begin
          cur_src_q <= src_e'(stk_top[ENT_W-1 -: 2]);
          cur_id_q  <= stk_top[ADDR_W +: ID_W];
          cur_reg_q <= stk_top[ADDR_W-1:0];
        end else begin
          cur_src_q <= SRC_IDLE;
          cur_id_q  <= IDLE_ID;
          cur_reg_q <= '0;
        end
      end else if (take) begin
        cur_src_q <= cand_hw ? SRC_HW : SRC_SW;
        cur_id_q  <= cand_id;
        cur_reg_q <= new_reg;
      end
    end
  end

  assign irq_take_o     = take_q;
  assign irq_active_o   = active;
  assign irq_id_o       = cur_id_q;
  assign irq_reg_o      = cur_reg_q;
  assign irq_addr_o     = (cur_src_q == SRC_HW) ? cur_reg_q + ADDR_W'(VEC_BASE) : cur_reg_q;
  assign irq_overflow_o = ovf_q;

  AST_IDLE_NULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_active_o |-> (irq_reg_o == '0 && irq_id_o == IDLE_ID)); // R1
  AST_HW_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_take_o && irq_id_o < SW_ID) |-> irq_reg_o == ADDR_W'(int'(irq_id_o) * VEC_STRIDE)); // R2
  AST_TAKE_OUTRANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (irq_take_o && irq_id_o < $past(cur_lvl))); // R6
  AST_OVF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_overflow_o |-> (!irq_take_o && $stable(irq_id_o))); // R9
  AST_DONE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_eff |=> !irq_take_o); // R11
  AST_SRC_MATCHES_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_active_o |-> ((cur_src_q == SRC_SW) == (irq_id_o == SW_ID))); // R3
endmodule

// File: tb/nested_irq_ctrl_tb.sv
module nested_irq_ctrl_tb;
  localparam int N    = 4;
  localparam int AW   = 16;
  localparam int BASE = 'h0100;
  localparam int STR  = 8;
  localparam int DEP  = 2;
  localparam int IW   = $clog2(N + 2);
  localparam int IDLE = N + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] hw_req = '0;
  logic sw_req = 1'b0;
  logic [AW-1:0] sw_addr = '0;
  logic done = 1'b0;
  logic take, active, ovf;
  logic [IW-1:0] id;
  logic [AW-1:0] rg, addr;

  always #5 clk = ~clk;

  nested_irq_ctrl #(.N_HW(N), .ADDR_W(AW), .VEC_BASE(BASE), .VEC_STRIDE(STR),
                    .STACK_DEPTH(DEP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .sw_req_i(sw_req),
    .sw_addr_i(sw_addr), .irq_done_i(done), .irq_take_o(take),
    .irq_active_o(active), .irq_id_o(id), .irq_reg_o(rg), .irq_addr_o(addr),
    .irq_overflow_o(ovf));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  bit m_act, m_take, m_ovf, m_swp;
  int m_id, m_reg, m_swa;
  bit m_pend[N];
  int s_id[$], s_reg[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_take = 0; m_ovf = 0; m_swp = 0;
      m_id = IDLE; m_reg = 0; m_swa = 0;
      foreach (m_pend[i]) m_pend[i] = 0;
      s_id.delete(); s_reg.delete();
    end else begin
      int cand, cur;
      cand = -1;
      for (int i = 0; i < N; i++) if (m_pend[i] && cand < 0) cand = i;
      if (cand < 0 && m_swp) cand = N;
      cur = m_act ? m_id : IDLE;
      m_take = 0; m_ovf = 0;
      if (done && m_act) begin
        if (s_id.size() > 0) begin
          m_id = s_id.pop_back(); m_reg = s_reg.pop_back();
        end else begin
          m_act = 0; m_id = IDLE; m_reg = 0;
        end
      end else if (cand >= 0 && cand < cur) begin
        if (m_act && s_id.size() == DEP) m_ovf = 1;
        else begin
          if (m_act) begin s_id.push_back(m_id); s_reg.push_back(m_reg); end
          m_id = cand;
          m_reg = (cand < N) ? cand * STR : m_swa;
          m_act = 1; m_take = 1;
          if (cand < N) m_pend[cand] = 0; else m_swp = 0;
        end
      end
      for (int i = 0; i < N; i++) if (hw_req[i]) m_pend[i] = 1;
      if (sw_req && !m_swp) begin m_swp = 1; m_swa = int'(sw_addr); end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int e_addr;
      e_addr = !m_act ? 0 : (m_id < N ? ((BASE + m_reg) & 'hFFFF) : m_reg);
      chk("R2 take", int'(take), int'(m_take));
      chk("R9 overflow", int'(ovf), int'(m_ovf));
      chk("R8 active", int'(active), int'(m_act));
      chk("R5 id", int'(id), m_act ? m_id : IDLE);
      chk("R4 reg", int'(rg), m_act ? m_reg : 0);
      chk("R3 addr", int'(addr), e_addr);
    end
  end

  task automatic pulse_hw(int line);
    hw_req = N'(1 << line);
    @(negedge clk);
    hw_req = '0;
    @(negedge clk);
  endtask

  task automatic pulse_done();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset reg", int'(rg), 0);
    chk("R1 reset addr", int'(addr), 0);
    chk("R1 reset id", int'(id), IDLE);
    chk("R1 reset active", int'(active), 0);

    pulse_done(); @(negedge clk);
    chk("R8 done idle ignored", int'(active), 0);

    // software first, then the two-slot stack is filled
    sw_req = 1'b1; sw_addr = 16'h1234;
    @(negedge clk);
    sw_req = 1'b1; sw_addr = 16'h5555;   // held pending, address must not change
    @(negedge clk);
    sw_req = 1'b0;
    chk("R4 sw take", int'(take), 1);
    chk("R4 sw reg", int'(rg), 'h1234);
    chk("R4 sw id", int'(id), N);
    chk("R3 sw addr", int'(addr), 'h1234);

    pulse_hw(3);
    chk("R6 hw3 preempts sw", int'(id), 3);
    chk("R2 hw3 reg", int'(rg), 3 * STR);
    chk("R3 hw3 addr", int'(addr), BASE + 3 * STR);
    pulse_hw(2);
    chk("R6 hw2 preempts", int'(id), 2);
    pulse_hw(1);
    chk("R9 overflow raised", int'(ovf), 1);
    chk("R9 active unchanged", int'(id), 2);

    pulse_done();
    chk("R11 no take on done", int'(take), 0);
    chk("R8 restore hw3", int'(id), 3);
    @(negedge clk);
    chk("R9 held request taken", int'(id), 1);
    chk("R2 hw1 take", int'(take), 1);

    pulse_hw(2);
    chk("R7 lower stays pending", int'(id), 1);
    chk("R7 no take", int'(take), 0);
    pulse_done();
    chk("R8 restore hw3 again", int'(id), 3);
    @(negedge clk);
    chk("R7 pending taken after unwind", int'(id), 2);
    pulse_done(); @(negedge clk);
    chk("R8 back to hw3", int'(id), 3);
    pulse_done(); @(negedge clk);
    chk("R4 sw restored", int'(rg), 'h1234);
    chk("R5 sw latched second request", int'(take), 0);
    pulse_done(); @(negedge clk);
    // second software request is still pending and is taken now
    chk("R4 sw second addr", int'(rg), 'h5555);
    pulse_done(); @(negedge clk);
    chk("R1 idle again", int'(rg), 0);

    // simultaneous arrivals
    hw_req = 4'b1010; sw_req = 1'b1; sw_addr = 16'h0abc;
    @(negedge clk);
    hw_req = '0; sw_req = 1'b0;
    @(negedge clk);
    chk("R5 most urgent first", int'(id), 1);
    pulse_done(); @(negedge clk);
    chk("R5 then line 3", int'(id), 3);
    pulse_done(); @(negedge clk);
    chk("R5 then software", int'(id), N);
    pulse_done(); @(negedge clk);
    chk("R1 idle after drain", int'(active), 0);

    pulse_hw(2);
    pulse_done();
    repeat (4) @(negedge clk);
    chk("R10 single pulse taken once", int'(active), 0);

    for (int k = 0; k < 4000; k++) begin
      hw_req  = ($urandom % 6 == 0) ? N'($urandom) : '0;
      sw_req  = ($urandom % 12 == 0);
      sw_addr = AW'($urandom);
      done    = ($urandom % 4 == 0);
      @(negedge clk);
    end
    hw_req = '0; sw_req = 1'b0; done = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule